// File: doc/BRIEF.md
# Quad 8-bit trim DAC serial control front end

This block is the digital side of a four-channel, 8-bit voltage-trim converter. A host writes to it over a three-wire serial port: an active-low select, a serial clock and a data line. Each access is a 12-bit word, sent most significant bit first. The upper four bits are a command and the lower eight bits are a data byte. Every channel is double-buffered. A command can write a channel's staging (input) register alone, or write the staging register and the output (DAC) register together. All output registers can be refreshed from their staging registers at the same moment, either by a software command or by a falling edge on an active-low load pin.

The serial pins, the load pin and the clear pin come from outside the chip. A fast system clock oversamples the serial, select and load pins through two-flop synchronizers, and the block works on the edges it detects. The incoming bit stream also leaves on a serial output, so several parts can be daisy-chained. A static mode input picks the output timing. In one mode the output moves on the rising serial-clock edge, 12 clocks after the bit went in. In the other it moves on the falling edge, 12½ clocks after. An asynchronous active-low clear, which also acts as the power-on reset, zeroes every register. The four output codes, a shutdown flag and a user-programmable logic output feed the analog section.

Top module: `quad_trim_dac`

## Requirements
- R1: While `clr_n` is low, every staging register, every output register, `shdn`, `user_out` and `dout` read zero.
- R2: A word is taken only when `cs_n` rises after exactly 12 rising `sclk` edges, counted while `cs_n` was low. Bit 11 (the first bit sent) through bit 8 form the command and bits 7..0 form the data. Words of any other length change nothing.
- R3: Command `01aa` writes the data byte into the staging register of channel `aa` and leaves every output code unchanged. Channel `n` drives `dac_code[8n+7:8n]`.
- R4: Command `10aa` writes the data byte into both the staging register and the output register of channel `aa`.
- R5: Command `0001` copies all four staging registers into their output registers.
- R6: A falling edge on `ldac_n` copies all four staging registers into their output registers, whatever the shift register holds.
- R7: Command `1111` writes the data byte into all four staging and all four output registers.
- R8: Command `1100` sets `shdn` and command `1101` clears it. Command `0000` changes no output.
- R9: Command `1110` sets `user_out` to data bit 0.
- R10: With `dout_mode` = 1, `dout` changes only after a rising `sclk` edge. After rising edge k it shows the bit shifted in at edge k-12, or 0 if fewer than 12 bits have been shifted in since the clear.
- R11: With `dout_mode` = 0, `dout` changes only after a falling `sclk` edge. After falling edge k it shows the bit shifted in at rising edge k-12, which gives a delay of 12½ clocks.
- R12: `sclk` edges while `cs_n` is high shift nothing and leave `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| clr_n | input | 1 | Asynchronous active-low clear and power-on reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in, MSB first |
| ldac_n | input | 1 | Active-low simultaneous load; acts on its falling edge |
| dout_mode | input | 1 | Daisy-chain timing: 1 = rising edge, 12 clocks; 0 = falling edge, 12½ clocks |
| dout | output | 1 | Daisy-chain serial output |
| dac_code | output | 32 | Four 8-bit output codes, channel 0 in bits 7..0 |
| shdn | output | 1 | Software shutdown flag |
| user_out | output | 1 | User-programmable logic output |

## Verification
Every pin edge passes through two synchronizer stages and one edge-detect register. A register inside the block therefore acts on the third `clk` edge after the pin changes. The result can be read one cycle later. The bench holds each serial-clock phase for four `clk` cycles and samples `dout` just before the next phase begins. It waits six cycles after `cs_n` rises, or after `ldac_n` falls, before it reads the output codes and flags. Because of this margin, no check depends on the exact edge at which the synchronizer captures a pin.

// File: rtl/quad_trim_pkg.sv
package quad_trim_pkg;

  localparam int NCH    = 4;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = $clog2(NCH);

  typedef struct packed {
    logic              ld_in;
    logic              ld_dac;
    logic              all_ch;
    logic              upd_all;
    logic              sd_set;
    logic              sd_clr;
    logic              uo_set;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] c);
    cmd_t d;
    d      = '0;
    d.addr = c[ADDR_W-1:0];
    case (c[CMD_W-1:CMD_W-2])
      2'b00: d.upd_all = (c[1:0] == 2'b01);
      2'b01: d.ld_in   = 1'b1;
      2'b10: begin
        d.ld_in  = 1'b1;
        d.ld_dac = 1'b1;
      end
      default: begin
        case (c[1:0])
          2'b00:   d.sd_set = 1'b1;
          2'b01:   d.sd_clr = 1'b1;
          2'b10:   d.uo_set = 1'b1;
          default: begin
            d.ld_in  = 1'b1;
            d.ld_dac = 1'b1;
            d.all_ch = 1'b1;
          end
        endcase
      end
    endcase
    return d;
  endfunction

  function automatic logic ch_hit(input cmd_t d, input int ch);
    return d.all_ch || (int'(d.addr) == ch);
  endfunction

endpackage

// File: rtl/qt_pin_sync.sv
module qt_pin_sync #(
  parameter int             N       = 3,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
        s3 <= RST_VAL[i];
      end else begin
        s1 <= pin[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[i] = s2;
    assign prv[i] = s3;
  end

endmodule

// File: rtl/qt_frame_shifter.sv
module qt_frame_shifter #(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               din_pin,
  input  logic               cs_active,
  input  logic               cs_begin,
  input  logic               cs_end,
  input  logic               sclk_up,
  input  logic               sclk_down,
  input  logic               dout_mode,
  output logic               frame_done,
  output logic [FRAME_W-1:0] frame_word,
  output logic               dout
);

  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_SAT = FRAME_W + 1;

  logic             din_s1, din_s2;
  logic [CNT_W-1:0] bit_cnt;
  logic             out_r, out_f;
  logic             shift_en, fall_en;

  assign shift_en = sclk_up && cs_active;
  assign fall_en  = sclk_down && cs_active;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      din_s1 <= 1'b0;
      din_s2 <= 1'b0;
    end else begin
      din_s1 <= din_pin;
      din_s2 <= din_s1;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      frame_word <= '0;
      out_r      <= 1'b0;
    end else if (shift_en) begin
      frame_word <= {frame_word[FRAME_W-2:0], din_s2};
      out_r      <= frame_word[FRAME_W-1];
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)       out_f <= 1'b0;
    else if (fall_en) out_f <= out_r;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)                  bit_cnt <= '0;
    else if (cs_begin || cs_end) bit_cnt <= '0;
    else if (shift_en && (bit_cnt != CNT_W'(CNT_SAT)))
      bit_cnt <= bit_cnt + 1'b1;
  end

  assign frame_done = cs_end && (bit_cnt == CNT_W'(FRAME_W));
  assign dout       = dout_mode ? out_r : out_f;

endmodule

// File: rtl/qt_channel_bank.sv
module qt_channel_bank
  import quad_trim_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            clr_n,
  input  logic            wr_en,
  input  cmd_t            cmd,
  input  logic [DW-1:0]   data,
  input  logic            ldac_fall,
  output logic [NCH*DW-1:0] in_flat,
  output logic [NCH*DW-1:0] dac_flat
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] in_q, dac_q;
    logic          sel, wr_in, wr_dac, xfer;

    assign sel    = ch_hit(cmd, ch);
    assign wr_in  = wr_en && cmd.ld_in && sel;
    assign wr_dac = wr_en && cmd.ld_dac && sel;
    assign xfer   = ldac_fall || (wr_en && cmd.upd_all);

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)     in_q <= '0;
      else if (wr_in) in_q <= data;
    end

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)       dac_q <= '0;
      else if (wr_dac)  dac_q <= data;
      else if (xfer)    dac_q <= in_q;
    end

    assign in_flat[ch*DW +: DW]  = in_q;
    assign dac_flat[ch*DW +: DW] = dac_q;
  end

endmodule

// File: rtl/quad_trim_dac.sv
module quad_trim_dac
  import quad_trim_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              ldac_n,
  input  logic              dout_mode,
  output logic              dout,
  output logic [NCH*DW-1:0] dac_code,
  output logic              shdn,
  output logic              user_out
);

  localparam int FRAME_W = CMD_W + DW;
  localparam int P_CS    = 0;
  localparam int P_SCLK  = 1;
  localparam int P_LDAC  = 2;

  logic [2:0]          p_lvl, p_prv;
  logic                cs_begin, cs_end, cs_active;
  logic                sclk_up, sclk_down, ldac_fall;
  logic                frame_done;
  logic [FRAME_W-1:0]  frame_word;
  logic [DW-1:0]       frame_data;
  cmd_t                cmd;
  logic [NCH*DW-1:0]   in_flat;

  qt_pin_sync #(.N(3), .RST_VAL(3'b101)) u_sync (
    .clk   (clk),
    .clr_n (clr_n),
    .pin   ({ldac_n, sclk, cs_n}),
    .lvl   (p_lvl),
    .prv   (p_prv)
  );

  assign cs_active = !p_lvl[P_CS];
  assign cs_begin  = !p_lvl[P_CS] && p_prv[P_CS];
  assign cs_end    = p_lvl[P_CS] && !p_prv[P_CS];
  assign sclk_up   = p_lvl[P_SCLK] && !p_prv[P_SCLK];
  assign sclk_down = !p_lvl[P_SCLK] && p_prv[P_SCLK];
  assign ldac_fall = !p_lvl[P_LDAC] && p_prv[P_LDAC];

  qt_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .clr_n      (clr_n),
    .din_pin    (din),
    .cs_active  (cs_active),
    .cs_begin   (cs_begin),
    .cs_end     (cs_end),
    .sclk_up    (sclk_up),
    .sclk_down  (sclk_down),
    .dout_mode  (dout_mode),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .dout       (dout)
  );

  assign cmd        = decode_cmd(frame_word[FRAME_W-1:DW]);
  assign frame_data = frame_word[DW-1:0];

  qt_channel_bank #(.DW(DW)) u_bank (
    .clk       (clk),
    .clr_n     (clr_n),
    .wr_en     (frame_done),
    .cmd       (cmd),
    .data      (frame_data),
    .ldac_fall (ldac_fall),
    .in_flat   (in_flat),
    .dac_flat  (dac_code)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      shdn     <= 1'b0;
      user_out <= 1'b0;
    end else if (frame_done) begin
      if (cmd.sd_set)      shdn <= 1'b1;
      else if (cmd.sd_clr) shdn <= 1'b0;
      if (cmd.uo_set)      user_out <= frame_data[0];
    end
  end

endmodule

// File: rtl/quad_trim_chk.sv
module quad_trim_chk
  import quad_trim_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              clr_n,
  input logic              frame_done,
  input cmd_t              cmd,
  input logic [DW-1:0]     frame_data,
  input logic              ldac_fall,
  input logic [NCH*DW-1:0] in_flat,
  input logic [NCH*DW-1:0] dac_code,
  input logic              shdn,
  input logic              user_out,
  input logic              dout
);

  // R1
  always @(posedge clk) begin
    if (!clr_n) begin
      clear_zero_chk: assert (dac_code == '0 && in_flat == '0 && !shdn && !user_out && !dout);
    end
  end

  // R2
  in_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !frame_done |=> $stable(in_flat));

  // R3
  dac_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!frame_done && !ldac_fall) |=> $stable(dac_code));

  // R5
  upd_all_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (frame_done && cmd.upd_all) |=> (dac_code == $past(in_flat)));

  // R6
  ldac_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ldac_fall && !frame_done) |=> (dac_code == $past(in_flat)));

  // R8
  shdn_set_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (frame_done && cmd.sd_set) |=> shdn);

  // R8
  shdn_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !frame_done |=> $stable(shdn));

  // R9
  user_out_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (frame_done && cmd.uo_set) |=> (user_out == $past(frame_data[0])));

endmodule

bind quad_trim_dac quad_trim_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .clr_n      (clr_n),
  .frame_done (frame_done),
  .cmd        (cmd),
  .frame_data (frame_data),
  .ldac_fall  (ldac_fall),
  .in_flat    (in_flat),
  .dac_code   (dac_code),
  .shdn       (shdn),
  .user_out   (user_out),
  .dout       (dout)
);

// File: tb/sim_quad_trim_dac.sv
`timescale 1ns/1ps
module sim_quad_trim_dac;

  logic        clk = 1'b0;
  logic        clr_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0, ldac_n = 1'b1, dout_mode = 1'b1;
  logic        dout, shdn, user_out;
  logic [31:0] dac_code;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  quad_trim_dac u0 (
    .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .ldac_n(ldac_n), .dout_mode(dout_mode), .dout(dout),
    .dac_code(dac_code), .shdn(shdn), .user_out(user_out)
  );

  typedef struct packed {
    logic [11:0] frm;
    logic [31:0] dac;
    logic        sd;
    logic        uo;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{12'h412, 32'h00000000, 1'b0, 1'b0},  // R3 stage ch0
    '{12'h100, 32'h00000012, 1'b0, 1'b0},  // R5 update all
    '{12'h9A5, 32'h0000A512, 1'b0, 1'b0},  // R4 ch1 both
    '{12'h63C, 32'h0000A512, 1'b0, 1'b0},  // R3 stage ch2
    '{12'hC00, 32'h0000A512, 1'b1, 1'b0},  // R8 shutdown
    '{12'hE01, 32'h0000A512, 1'b1, 1'b1},  // R9 user out high
    '{12'h0FF, 32'h0000A512, 1'b1, 1'b1},  // R8 no-op
    '{12'hD00, 32'h0000A512, 1'b0, 1'b1},  // R8 wake
    '{12'h100, 32'h003CA512, 1'b0, 1'b1},  // R5 update all
    '{12'hB77, 32'h773CA512, 1'b0, 1'b1},  // R4 ch3 both
    '{12'hE02, 32'h773CA512, 1'b0, 1'b0},  // R9 user out low
    '{12'hF5A, 32'h5A5A5A5A, 1'b0, 1'b0}   // R7 all
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    @(negedge clk) cs_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic do_clear();
    @(negedge clk) clr_n = 1'b0;
    wait_clk(2);
    clr_n = 1'b1;
    wait_clk(3);
  endtask

  localparam logic [23:0] STREAM = 24'hB38E5D;

  function automatic logic sbit(input int k);
    return (k < 0) ? 1'b0 : STREAM[23 - k];
  endfunction

  initial begin
    wait_clk(3);
    // R1 reset state
    check("R1 reset dac", dac_code, 0);
    check("R1 reset flags", {shdn, user_out, dout}, 0);
    clr_n = 1'b1;
    wait_clk(3);

    for (int v = 0; v < 12; v++) begin
      send_bits({20'h0, VECS[v].frm}, 12);
      check($sformatf("vector %0d dac", v), dac_code, VECS[v].dac);
      check($sformatf("vector %0d flags", v), {shdn, user_out}, {VECS[v].sd, VECS[v].uo});
    end

    // R2 short and long words ignored
    send_bits(32'h7FF, 11);
    send_bits(32'h1F11, 13);
    send_bits(32'h9, 4);
    check("R2 wrong length", dac_code, 32'h5A5A5A5A);

    // R3 stage ch3 only, then R6 load pin copies
    send_bits(32'h799, 12);
    check("R3 stage ch3", dac_code, 32'h5A5A5A5A);
    @(negedge clk) ldac_n = 1'b0;
    wait_clk(6);
    ldac_n = 1'b1;
    wait_clk(4);
    check("R6 load pin", dac_code, 32'h995A5A5A);

    // R1 clear mid-run
    send_bits(32'hC00, 12);
    do_clear();
    check("R1 clear dac", dac_code, 0);
    check("R1 clear flags", {shdn, user_out, dout}, 0);

    // R12 clocks with select high
    din = 1'b1;
    for (int i = 0; i < 14; i++) begin
      wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    wait_clk(4);
    check("R12 no shift when deselected", dout, 0);

    // R10 rising-edge 12 clock delay
    dout_mode = 1'b1;
    do_clear();
    @(negedge clk) cs_n = 1'b0;
    wait_clk(4);
    for (int k = 0; k < 24; k++) begin
      din = sbit(k);
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      check($sformatf("R10 rise %0d", k), dout, sbit(k - 12));
      sclk = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(6);
    check("R2 long stream ignored", dac_code, 0);

    // R11 falling-edge 12.5 clock delay
    dout_mode = 1'b0;
    do_clear();
    @(negedge clk) cs_n = 1'b0;
    wait_clk(4);
    for (int k = 0; k < 24; k++) begin
      din = sbit(k);
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      check($sformatf("R11 after rise %0d", k), dout, sbit(k - 13));
      sclk = 1'b0;
      wait_clk(4);
      check($sformatf("R11 after fall %0d", k), dout, sbit(k - 12));
    end
    cs_n = 1'b1;
    wait_clk(6);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule